// File: doc/BRIEF.md
# Configuration Access Translator

This block sits in a host bridge and turns host accesses into configuration cycles. The host uses two apertures. The first is an index register that holds a 32-bit selector. The second is a data window. Each access through the data window is sent as one request to a configuration target. The request carries an address built from the stored selector and the low offset bits of the access, together with the byte count, the direction and the write data.

The selector may take one of three encodings, and all three end up in a single canonical address layout:

- **Pass-through form.** The top bit is set, and the selector is forwarded as is.
- **Forwarded-bus form.** The top bit is clear and bit 0 is set.
- **Local form.** Bits 31 and 0 are both clear. A one-hot field in the upper bits picks the device, and the block turns that field into a slot number by searching for its lowest set bit. The search is combinational, so translation finishes in the cycle of the access.

Writes through the data window are posted: the host is acknowledged in the same cycle that the request goes out. A read holds the host until the target answers. Data is little-endian and right-aligned, and only the bytes within the access length are significant.

Top module: `cfg_xlate`

## Requirements
- R1: After reset the index register reads 0, and `treq_o` and `hack_o` are low.
- R2: An index-register write (`hwin_i`=0, `hwr_i`=1) stores all 32 bits of `hwdata_i`. An index read returns the stored value on `hrdata_o`, with `hack_o` high in the cycle after the access.
- R3: When selector bit 31 is 1, the target address is the selector ORed with `hofs_i[1:0]`.
- R4: When selector bit 31 is 0 and bit 0 is 1, the target address is selector bits 31:3 with bits 2:0 replaced by `hofs_i[2:0]`.
- R5: When selector bits 31 and 0 are both 0 and any of bits 31:11 is set, address bits 31:11 hold the zero-extended index (0 for bit 11) of the lowest set bit in selector bits 31:11.
- R6: In the same local form with selector bits 31:11 all zero, address bits 31:11 are all ones.
- R7: In the local form, address bits 10:8 (function) and 7:3 (register) are copied from the selector, and bits 2:0 come from `hofs_i`.
- R8: A data-window access (`hwin_i`=1) raises `treq_o` for one cycle, in the cycle after the access. The request carries the translated address, `tlen_o`=`hlen_i` (byte count 1, 2 or 4), `twr_o`=`hwr_i`, and `twdata_o`=`hwdata_i` with the bytes at and above the length cleared.
- R9: A data-window write is posted: `hack_o` is high in the same cycle as its `treq_o`.
- R10: A data-window read holds the host. `hack_o` is high in the cycle after `tresp_i` is sampled high, and `hrdata_o` then equals `trdata_i` with the bytes at and above the length cleared. Host accesses presented while the read is pending are ignored, and this includes index writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hv_i | input | 1 | Host access valid (one cycle) |
| hwin_i | input | 1 | 0 = index register, 1 = data window |
| hwr_i | input | 1 | 1 = write, 0 = read |
| hofs_i | input | 3 | Low offset bits of the host access |
| hlen_i | input | 3 | Access byte count: 1, 2 or 4 |
| hwdata_i | input | 32 | Host write data, right-aligned |
| hack_o | output | 1 | Host access complete |
| hrdata_o | output | 32 | Host read data |
| treq_o | output | 1 | Configuration request strobe |
| taddr_o | output | 32 | Canonical configuration address |
| tlen_o | output | 3 | Request byte count |
| twr_o | output | 1 | Request direction, 1 = write |
| twdata_o | output | 32 | Request write data, masked to length |
| tresp_i | input | 1 | Target read response valid |
| trdata_i | input | 32 | Target read data |

## Verification
The assertions check properties that must hold on every cycle:

- the index register changes only on an accepted index write;
- a posted write raises both strobes together;
- a pending read raises no second request and no early acknowledge;
- in the local form, the recovered slot always points at a set selector bit, or the upper field is all ones when no bit is set.

The exact address values for each encoding, the byte masking, and the fact that an access presented mid-read is dropped can only be shown by the bench scenarios. Those scenarios compare every output against the reference model on every clock.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
   // selector encodings recognised by the translator
   typedef enum logic [1:0] {
      FMT_RAW = 2'd0,
      FMT_T1  = 2'd1,
      FMT_T0  = 2'd2
   } fmt_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } seq_st_e;
endpackage

// File: rtl/cfgx_lsb_find.sv
module cfgx_lsb_find #(
   parameter int W     = 21,
   parameter int IDX_W = 5
) (
   input  logic [W-1:0]     vec_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             found_o
);
   logic [W-1:0] clear_below;
   logic [W-1:0] hit;

   assign clear_below[0] = 1'b1;
   for (genvar i = 1; i < W; i++) begin : g_chain
      assign clear_below[i] = clear_below[i-1] & ~vec_i[i-1];
   end

   assign hit     = vec_i & clear_below;
   assign found_o = |vec_i;

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < W; i++) begin
         if (hit[i]) idx_o = idx_o | IDX_W'(i);
      end
   end
endmodule

// File: rtl/cfgx_addr_map.sv
module cfgx_addr_map
   import cfgx_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int SLOT_LO = 11,
   parameter int OFS_W   = 3,
   parameter int IDX_W   = 5
) (
   input  logic [ADDR_W-1:0] sel_i,
   input  logic [OFS_W-1:0]  ofs_i,
   output logic [ADDR_W-1:0] addr_o,
   output fmt_e              fmt_o,
   output logic              found_o,
   output logic [IDX_W-1:0]  slot_o
);
   localparam int ONEHOT_W = ADDR_W - SLOT_LO;
   localparam int RAW_OW   = OFS_W - 1;

   logic [IDX_W-1:0] slot_idx;
   logic             slot_found;

   cfgx_lsb_find #(.W(ONEHOT_W), .IDX_W(IDX_W)) u_find (
      .vec_i   (sel_i[ADDR_W-1:SLOT_LO]),
      .idx_o   (slot_idx),
      .found_o (slot_found)
   );

   assign found_o = slot_found;
   assign slot_o  = slot_idx;

   always_comb begin
      if (sel_i[ADDR_W-1])  fmt_o = FMT_RAW;
      else if (sel_i[0])    fmt_o = FMT_T1;
      else                  fmt_o = FMT_T0;
   end

   always_comb begin
      addr_o = '0;
      unique case (fmt_o)
         FMT_RAW: addr_o = sel_i | ADDR_W'(ofs_i[RAW_OW-1:0]);
         FMT_T1:  addr_o = {sel_i[ADDR_W-1:OFS_W], ofs_i};
         default: begin
            addr_o[SLOT_LO-1:OFS_W] = sel_i[SLOT_LO-1:OFS_W];
            addr_o[OFS_W-1:0]       = ofs_i;
            if (slot_found) addr_o[ADDR_W-1:SLOT_LO] = ONEHOT_W'(slot_idx);
            else            addr_o[ADDR_W-1:SLOT_LO] = '1;
         end
      endcase
   end
endmodule

// File: rtl/cfgx_lane_mask.sv
module cfgx_lane_mask #(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 3
) (
   input  logic [LEN_W-1:0]  len_i,
   output logic [DATA_W-1:0] mask_o
);
   localparam int BYTES = DATA_W / 8;

   for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign mask_o[b*8 +: 8] = {8{32'(len_i) > b}};
   end
endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq
   import cfgx_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LEN_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hv_i,
   input  logic              hwin_i,
   input  logic              hwr_i,
   input  logic [LEN_W-1:0]  hlen_i,
   input  logic [DATA_W-1:0] hwdata_i,
   input  logic [DATA_W-1:0] wdata_m_i,
   input  logic [ADDR_W-1:0] xaddr_i,
   input  logic              tresp_i,
   input  logic [DATA_W-1:0] rdata_m_i,
   output logic [ADDR_W-1:0] sel_o,
   output logic              hack_o,
   output logic [DATA_W-1:0] hrdata_o,
   output logic              treq_o,
   output logic [ADDR_W-1:0] taddr_o,
   output logic [LEN_W-1:0]  tlen_o,
   output logic              twr_o,
   output logic [DATA_W-1:0] twdata_o
);
   seq_st_e st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         sel_o    <= '0;
         hack_o   <= 1'b0;
         hrdata_o <= '0;
         treq_o   <= 1'b0;
         taddr_o  <= '0;
         tlen_o   <= '0;
         twr_o    <= 1'b0;
         twdata_o <= '0;
      end else begin
         treq_o <= 1'b0;
         hack_o <= 1'b0;
         unique case (st)
            ST_IDLE: if (hv_i) begin
               if (!hwin_i) begin
                  if (hwr_i) sel_o    <= ADDR_W'(hwdata_i);
                  else       hrdata_o <= DATA_W'(sel_o);
                  hack_o <= 1'b1;
               end else begin
                  treq_o   <= 1'b1;
                  taddr_o  <= xaddr_i;
                  tlen_o   <= hlen_i;
                  twr_o    <= hwr_i;
                  twdata_o <= wdata_m_i;
                  if (hwr_i) hack_o <= 1'b1;
                  else       st     <= ST_WAIT;
               end
            end
            ST_WAIT: if (tresp_i) begin
               hrdata_o <= rdata_m_i;
               hack_o   <= 1'b1;
               st       <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R2
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(st == ST_IDLE && hv_i && !hwin_i && hwr_i) |=> $stable(sel_o));
   // R9
   post_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && hv_i && hwin_i && hwr_i) |=> (hack_o && treq_o));
   // R10
   wait_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && $past(st == ST_WAIT)) |-> !treq_o);
   // R10
   wait_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && !tresp_i) |=> !hack_o);
endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
   import cfgx_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int SLOT_LO = 11,
   parameter int OFS_W   = 3,
   parameter int LEN_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hv_i,
   input  logic              hwin_i,
   input  logic              hwr_i,
   input  logic [OFS_W-1:0]  hofs_i,
   input  logic [LEN_W-1:0]  hlen_i,
   input  logic [DATA_W-1:0] hwdata_i,
   output logic              hack_o,
   output logic [DATA_W-1:0] hrdata_o,
   output logic              treq_o,
   output logic [ADDR_W-1:0] taddr_o,
   output logic [LEN_W-1:0]  tlen_o,
   output logic              twr_o,
   output logic [DATA_W-1:0] twdata_o,
   input  logic              tresp_i,
   input  logic [DATA_W-1:0] trdata_i
);
   localparam int ONEHOT_W = ADDR_W - SLOT_LO;
   localparam int IDX_W    = $clog2(ONEHOT_W);
   localparam int BYTES    = DATA_W / 8;

   if (ADDR_W != DATA_W) begin : g_bad_w
      $error("selector and data widths must match");
   end
   if (DATA_W % 8 != 0) begin : g_bad_d
      $error("data width must be whole bytes");
   end
   if (OFS_W < 2 || SLOT_LO <= OFS_W || SLOT_LO >= ADDR_W) begin : g_bad_f
      $error("field layout inconsistent");
   end
   if (BYTES >= (1 << LEN_W)) begin : g_bad_l
      $error("length field too narrow");
   end
   if (IDX_W > ONEHOT_W) begin : g_bad_i
      $error("slot index wider than its field");
   end

   logic [ADDR_W-1:0] sel_q;
   logic [ADDR_W-1:0] xaddr;
   fmt_e              xfmt;
   logic              xfound;
   logic [IDX_W-1:0]  xslot;
   logic [DATA_W-1:0] wmask;
   logic [DATA_W-1:0] rmask;

   cfgx_addr_map #(
      .ADDR_W(ADDR_W), .SLOT_LO(SLOT_LO), .OFS_W(OFS_W), .IDX_W(IDX_W)
   ) u_map (
      .sel_i   (sel_q),
      .ofs_i   (hofs_i),
      .addr_o  (xaddr),
      .fmt_o   (xfmt),
      .found_o (xfound),
      .slot_o  (xslot)
   );

   cfgx_lane_mask #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_wmask (
      .len_i  (hlen_i),
      .mask_o (wmask)
   );

   cfgx_lane_mask #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_rmask (
      .len_i  (tlen_o),
      .mask_o (rmask)
   );

   cfgx_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .hv_i      (hv_i),
      .hwin_i    (hwin_i),
      .hwr_i     (hwr_i),
      .hlen_i    (hlen_i),
      .hwdata_i  (hwdata_i),
      .wdata_m_i (hwdata_i & wmask),
      .xaddr_i   (xaddr),
      .tresp_i   (tresp_i),
      .rdata_m_i (trdata_i & rmask),
      .sel_o     (sel_q),
      .hack_o    (hack_o),
      .hrdata_o  (hrdata_o),
      .treq_o    (treq_o),
      .taddr_o   (taddr_o),
      .tlen_o    (tlen_o),
      .twr_o     (twr_o),
      .twdata_o  (twdata_o)
   );

   // R3
   raw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfmt == FMT_RAW) |-> (xaddr[ADDR_W-1:OFS_W-1] == sel_q[ADDR_W-1:OFS_W-1]));
   // R5
   t0_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfmt == FMT_T0 && xfound) |-> sel_q[SLOT_LO + int'(xslot)]);
   // R6
   t0_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfmt == FMT_T0 && !xfound) |-> (&xaddr[ADDR_W-1:SLOT_LO]));
endmodule

// File: tb/cfg_xlate_tb.sv
`timescale 1ns/1ps
module cfg_xlate_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hv_i = 1'b0, hwin_i = 1'b0, hwr_i = 1'b0;
   logic [2:0]  hofs_i = '0, hlen_i = 3'd4;
   logic [31:0] hwdata_i = '0;
   logic        hack_o, treq_o, twr_o;
   logic [31:0] hrdata_o, taddr_o, twdata_o;
   logic [2:0]  tlen_o;
   logic        tresp_i = 1'b0;
   logic [31:0] trdata_i = '0;

   int nchk = 0, nerr = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cfg_xlate u_dut (
      .clk(clk), .rst_n(rst_n), .hv_i(hv_i), .hwin_i(hwin_i), .hwr_i(hwr_i),
      .hofs_i(hofs_i), .hlen_i(hlen_i), .hwdata_i(hwdata_i),
      .hack_o(hack_o), .hrdata_o(hrdata_o), .treq_o(treq_o), .taddr_o(taddr_o),
      .tlen_o(tlen_o), .twr_o(twr_o), .twdata_o(twdata_o),
      .tresp_i(tresp_i), .trdata_i(trdata_i)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_mask(input logic [2:0] len);
      if (len == 3'd1) return 32'h0000_00FF;
      if (len == 3'd2) return 32'h0000_FFFF;
      return 32'hFFFF_FFFF;
   endfunction

   function automatic string ref_tag(input logic [31:0] s);
      if (s[31]) return "R3";
      if (s[0])  return "R4";
      if (s[31:11] == 0) return "R6";
      return "R5 R7";
   endfunction

   function automatic logic [31:0] ref_xlate(input logic [31:0] s, input logic [2:0] o);
      int slot;
      logic [31:0] r;
      if (s[31]) return s | {30'b0, o[1:0]};
      if (s[0])  return {s[31:3], o};
      slot = -1;
      for (int i = 31; i >= 11; i--) if (s[i]) slot = i - 11;
      r = (s & 32'h0000_07F8) | {29'b0, o};
      r = r | (32'(slot) << 11);
      return r;
   endfunction

   // behavioural reference model
   logic [31:0] m_sel, m_taddr, m_twd, m_rdata;
   logic [2:0]  m_tlen;
   logic        m_treq, m_twr, m_hack, m_rdv, m_wait;
   string       m_atag, m_rtag;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sel <= 0; m_treq <= 0; m_hack <= 0; m_wait <= 0; m_rdv <= 0;
         m_taddr <= 0; m_twd <= 0; m_tlen <= 0; m_twr <= 0; m_rdata <= 0;
      end else begin
         m_treq <= 0; m_hack <= 0; m_rdv <= 0;
         if (m_wait) begin
            if (tresp_i) begin
               m_rdata <= trdata_i & ref_mask(m_tlen);
               m_hack <= 1; m_rdv <= 1; m_wait <= 0; m_rtag <= "R10";
            end
         end else if (hv_i) begin
            if (!hwin_i) begin
               if (hwr_i) m_sel <= hwdata_i;
               else begin m_rdata <= m_sel; m_rdv <= 1; m_rtag <= "R2"; end
               m_hack <= 1;
            end else begin
               m_treq <= 1;
               m_taddr <= ref_xlate(m_sel, hofs_i);
               m_atag <= ref_tag(m_sel);
               m_tlen <= hlen_i; m_twr <= hwr_i;
               m_twd <= hwdata_i & ref_mask(hlen_i);
               if (hwr_i) m_hack <= 1; else m_wait <= 1;
            end
         end
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk(treq_o === m_treq, "R8 treq", 32'(treq_o), 32'(m_treq));
         chk(hack_o === m_hack, "R9 R10 hack", 32'(hack_o), 32'(m_hack));
         if (m_treq) begin
            chk(taddr_o === m_taddr, {m_atag, " addr"}, taddr_o, m_taddr);
            chk(tlen_o === m_tlen, "R8 len", 32'(tlen_o), 32'(m_tlen));
            chk(twr_o === m_twr, "R8 dir", 32'(twr_o), 32'(m_twr));
            chk(twdata_o === m_twd, "R8 wdata", twdata_o, m_twd);
         end
         if (m_hack && m_rdv)
            chk(hrdata_o === m_rdata, {m_rtag, " rdata"}, hrdata_o, m_rdata);
      end
   end

   task automatic acc(input bit win, input bit wr, input logic [2:0] ofs,
                      input logic [2:0] len, input logic [31:0] wd);
      hv_i = 1; hwin_i = win; hwr_i = wr; hofs_i = ofs; hlen_i = len; hwdata_i = wd;
      @(negedge clk);
      hv_i = 0;
   endtask

   task automatic dread(input logic [2:0] ofs, input logic [2:0] len,
                        input int dly, input logic [31:0] rd);
      acc(1, 0, ofs, len, 32'h5A5A_5A5A);
      repeat (dly) @(negedge clk);
      tresp_i = 1; trdata_i = rd;
      @(negedge clk);
      tresp_i = 0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state at the ports
      chk(treq_o === 1'b0, "R1 treq", 32'(treq_o), 0);
      chk(hack_o === 1'b0, "R1 hack", 32'(hack_o), 0);
      rst_n = 1;
      @(negedge clk);
      acc(0, 0, 0, 4, 0);
      chk(hrdata_o === 32'h0, "R1 index after reset", hrdata_o, 0);

      // R2 index write and read back; R3 pass-through form
      acc(0, 1, 0, 4, 32'h8000_1234);
      acc(0, 0, 0, 4, 0);
      chk(hrdata_o === 32'h8000_1234, "R2 index readback", hrdata_o, 32'h8000_1234);
      acc(1, 1, 3'd5, 3'd1, 32'hAABB_CCDD);
      acc(1, 1, 3'd2, 3'd2, 32'h1122_3344);
      @(negedge clk);
      dread(3'd2, 3'd2, 3, 32'h1122_3344);
      chk(hrdata_o === 32'h0000_3344, "R10 masked read", hrdata_o, 32'h0000_3344);

      // R4 forwarded-bus form
      acc(0, 1, 0, 4, 32'h00AB_CD01);
      dread(3'd6, 3'd4, 0, 32'hCAFE_F00D);
      acc(1, 1, 3'd7, 3'd4, 32'h0102_0304);

      // R5 R7 local form with several slots
      acc(0, 1, 0, 4, 32'h0010_45F8);
      acc(1, 1, 3'd3, 3'd4, 32'h1);
      @(negedge clk);
      chk(taddr_o === 32'h0000_1DFB, "R5 R7 slot 3", taddr_o, 32'h0000_1DFB);
      acc(0, 1, 0, 4, 32'h0000_0800);
      dread(3'd1, 3'd1, 1, 32'hFFFF_FF99);
      chk(hrdata_o === 32'h0000_0099, "R10 one byte read", hrdata_o, 32'h99);
      acc(0, 1, 0, 4, 32'h4000_0000);
      acc(1, 1, 3'd0, 3'd4, 32'h2);
      @(negedge clk);
      chk(taddr_o === 32'h0000_9800, "R5 slot 19", taddr_o, 32'h0000_9800);

      // R6 local form with an empty device field
      acc(0, 1, 0, 4, 32'h0000_0304);
      acc(1, 1, 3'd4, 3'd2, 32'hFFFF_FFFF);
      @(negedge clk);
      chk(taddr_o === 32'hFFFF_FB04, "R6 all ones", taddr_o, 32'hFFFF_FB04);

      // R10 an index write during a pending read is ignored
      acc(0, 1, 0, 4, 32'h8000_0100);
      acc(1, 0, 3'd0, 3'd4, 0);
      acc(0, 1, 0, 4, 32'hDEAD_BEE0);
      repeat (2) @(negedge clk);
      tresp_i = 1; trdata_i = 32'h7777_8888;
      @(negedge clk);
      tresp_i = 0;
      acc(0, 0, 0, 4, 0);
      chk(hrdata_o === 32'h8000_0100, "R10 ignored index write", hrdata_o, 32'h8000_0100);

      repeat (3) @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end
endmodule